// File: doc/BRIEF.md
# Edge-Kicked Watchdog Monitor

This block watches a service signal from a processor and flags a fault when the processor stops changing it. Every change of level on the kick input, in either direction, restarts a timer that counts strobes from a shared timebase. When the timer has seen the full timeout count with no change, the fault output is pulled low. It stays low until the kick input changes again.

The timer is held at zero while the system reset from the reset generator is asserted. A flag that marks the kick input as undriven also holds the timer at zero, which switches the watchdog off. The supply-good flag has priority over everything else. A bad supply pulls the output low in the same cycle. When the supply recovers, the output releases in the same cycle, with no recovery delay.

The output can be looped back into the manual-reset input of a reset generator. With a static kick input, this gives one reset per timeout-plus-recovery interval. The reset clears the timer and the fault, and counting starts again when the reset is released.

Top module: `wdog_monitor`

## Requirements
- R1: After the asynchronous reset, the timer is zero and fault_n_o is 1 while supply_ok_i is 1.
- R2: With no kick change, fault_n_o goes to 0 on the strobe that completes TIMEOUT_TICKS strobes (tick_i high for one clock each). After TIMEOUT_TICKS-1 strobes it is still 1.
- R3: A rising change on kick_i restarts the count from zero.
- R4: A falling change on kick_i restarts the count from zero.
- R5: Once fault_n_o is 0 from a timeout, it stays 0 under further strobes. It returns to 1 within SYNC_STAGES+2 clocks of the next kick change.
- R6: While rst_active_i is 1, the count is held at zero and any timeout fault is cleared. After release, a full TIMEOUT_TICKS strobes are needed to fault again.
- R7: supply_ok_i at 0 forces fault_n_o to 0 in the same cycle, whatever the timer state.
- R8: When supply_ok_i returns to 1 and no timeout fault is pending, fault_n_o returns to 1 in the same cycle.
- R9: While kick_float_i is 1, the count is held at zero and fault_n_o follows supply_ok_i. After release, a full TIMEOUT_TICKS strobes are needed to fault.
- R10: Clocks without tick_i do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one clock wide |
| kick_i | input | 1 | Asynchronous service signal from the processor |
| rst_active_i | input | 1 | System reset currently asserted |
| supply_ok_i | input | 1 | Supply above the reset threshold |
| kick_float_i | input | 1 | Kick input undriven; disables the watchdog |
| fault_n_o | output | 1 | Push-pull fault flag, low on timeout or bad supply |

## Verification
The vector table mixes strobe bursts that stop one short of the timeout with bursts that reach it exactly. This separates an off-by-one timer from a correct one. Kick changes alternate between rising and falling, so losing either edge polarity leaves a fault or a missed restart. Directed passes cover the following:
- Holding the system reset and the float flag, which tells a held counter from one that merely pauses.
- Toggling the supply between clock edges, to expose any registered path on the supply.
- Long idle stretches without strobes, to catch counting on the raw clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/wdog_edge_det.sv
module wdog_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic change_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= kick_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[MSB-1:0], kick_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[MSB];

  // either polarity restarts the timer
  assign change_o = sync_q[MSB] ^ prev_q;

  a_r3_change_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o && $stable(kick_i) |=> !change_o || (SYNC_STAGES == 1));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int CNT_W = wdog_pkg::cnt_width(TIMEOUT_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic change_i,
  input  logic rst_active_i,
  input  logic float_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;
  logic             hold;

  assign hold = change_i | rst_active_i | float_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (hold) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (tick_i && !fault_q) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        fault_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired_o = fault_q;

  a_r6_hold_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active_i |=> cnt_q == '0 && !fault_q);
  a_r9_hold_when_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_i |=> cnt_q == '0 && !fault_q);
  a_r3_change_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_i |=> cnt_q == '0 && !fault_q);
  a_r10_no_tick_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !hold |=> $stable(cnt_q) && $stable(fault_q));
  a_r5_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && !hold |=> fault_q);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/wdog_monitor.sv
module wdog_monitor #(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kick_i,
  input  logic rst_active_i,
  input  logic supply_ok_i,
  input  logic kick_float_i,
  output logic fault_n_o
);
  localparam int CNT_W = wdog_pkg::cnt_width(TIMEOUT_TICKS);

  logic change;
  logic expired;

  wdog_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (kick_i),
    .change_o (change)
  );

  wdog_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .change_i     (change),
    .rst_active_i (rst_active_i),
    .float_i      (kick_float_i),
    .expired_o    (expired)
  );

  // supply path is combinational: no recovery delay
  assign fault_n_o = supply_ok_i & ~expired;

  a_r9_float_follows_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_float_i && $past(kick_float_i) |-> fault_n_o == supply_ok_i);
  a_r6_reset_clears_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_active_i) && rst_active_i |-> fault_n_o == supply_ok_i);
endmodule

// File: tb/tb_wdog_monitor.sv
module tb_wdog_monitor;
  localparam int TMO = 8;
  localparam int LIMIT = 100000;

  logic clk = 0, rst_ni = 0, tick_i = 0, kick_i = 0;
  logic rst_active_i = 0, supply_ok_i = 1, kick_float_i = 0;
  logic fault_n_o;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  wdog_monitor #(.TIMEOUT_TICKS(TMO), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
    .rst_active_i(rst_active_i), .supply_ok_i(supply_ok_i),
    .kick_float_i(kick_float_i), .fault_n_o(fault_n_o)
  );

  // [9] toggle kick first, [8:1] strobes, [0] expected fault_n_o
  localparam logic [9:0] VEC [0:9] = '{
    {1'b0, 8'd7, 1'b1},  // R2 one short
    {1'b0, 8'd1, 1'b0},  // R2 exact
    {1'b0, 8'd3, 1'b0},  // R5 sticky
    {1'b1, 8'd0, 1'b1},  // R5 rising clears
    {1'b0, 8'd7, 1'b1},
    {1'b1, 8'd7, 1'b1},  // R4 falling restarts
    {1'b0, 8'd1, 1'b0},
    {1'b1, 8'd5, 1'b1},  // R3 rising restarts
    {1'b1, 8'd7, 1'b1},  // R4
    {1'b0, 8'd1, 1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: fault_n_o=%b expected %b at t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1;
      @(negedge clk) tick_i = 0;
    end
  endtask

  task automatic toggle();
    @(negedge clk) kick_i = ~kick_i;
    repeat (5) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected below %0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 reset state", fault_n_o, 1'b1);

    for (int v = 0; v < 10; v++) begin
      if (VEC[v][9]) toggle();
      ticks(int'(VEC[v][8:1]));
      check($sformatf("R2/R3/R4/R5 vector %0d", v), fault_n_o, VEC[v][0]);
    end

    // R6: reset holds timer and clears fault
    toggle();
    ticks(5);
    @(negedge clk) rst_active_i = 1;
    ticks(20);
    check("R6 held during reset", fault_n_o, 1'b1);
    @(negedge clk) rst_active_i = 0;
    ticks(TMO - 1);
    check("R6 restart after release", fault_n_o, 1'b1);
    ticks(1);
    check("R6 timeout after release", fault_n_o, 1'b0);
    @(negedge clk) rst_active_i = 1;
    @(negedge clk);
    check("R6 reset clears fault", fault_n_o, 1'b1);
    @(negedge clk) rst_active_i = 0;

    // R7/R8: supply path is immediate
    ticks(3);
    @(negedge clk) supply_ok_i = 0;
    #1 check("R7 supply loss same cycle", fault_n_o, 1'b0);
    @(negedge clk) supply_ok_i = 1;
    #1 check("R8 supply recovery same cycle", fault_n_o, 1'b1);

    // R9: float disables
    @(negedge clk) kick_float_i = 1;
    ticks(30);
    check("R9 float holds timer", fault_n_o, 1'b1);
    @(negedge clk) supply_ok_i = 0;
    #1 check("R9 float still follows supply", fault_n_o, 1'b0);
    @(negedge clk) supply_ok_i = 1;
    @(negedge clk) kick_float_i = 0;
    ticks(TMO - 1);
    check("R9 full count after float", fault_n_o, 1'b1);

    // R10: idle clocks do not count
    repeat (60) @(negedge clk);
    check("R10 idle clocks ignored", fault_n_o, 1'b1);
    ticks(1);
    check("R10 last strobe faults", fault_n_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule